// File: doc/BRIEF.md
# Event Counter with Condition Output

This block counts edges of an asynchronous event input and raises an interrupt when the count wraps past its end value. It belongs to a scan-controlled test logic island that runs on the test clock. A control register outside the block drives the run level, the count direction, the active edge, and strobes that preset the count and capture it for serial readout. The TAP controller and the shift chains are not part of this block.

The block also drives the condition output pin. A small configuration register, reset to active-low open drain, sets the pin's polarity and drive mode. It also chooses whether the pin shows the counter interrupt or an instruction parity error flag that comes from outside. The pin is presented as a data level and an output enable, so the pad can build either open-drain or tri-state drive.

The event input passes through a two-stage synchroniser in the test-clock domain before edge detection. The count, the interrupt and the readout snapshot therefore all live in one clock domain.

Top module: `evt_cnt`

## Requirements
- R1: After reset the count is 0x00, the interrupt is clear, and the output configuration is active low, open drain, showing the interrupt. The pin is therefore released (`cond_oe_o` = 0).
- R2: With `run_i`=1, `up_i`=1 and `edge_fall_i`=0, each 0-to-1 transition of `evt_i` adds one to the count. The new count is visible no later than three clock edges after the transition.
- R3: With `edge_fall_i`=1, only 1-to-0 transitions of `evt_i` are counted, and 0-to-1 transitions leave the count unchanged.
- R4: With `up_i`=0, each active edge subtracts one from the count.
- R5: With `run_i`=0, edges on `evt_i` leave the count unchanged.
- R6: A `load_i` pulse sets the count to `load_data_i` on the next clock edge and clears the interrupt. The load wins over an event edge in the same cycle.
- R7: An up-count from 0xFF to 0x00 sets the interrupt. The interrupt then stays set through further counting until the next load.
- R8: A down-count from 0x00 to 0xFF sets the interrupt.
- R9: A `capture_i` pulse copies the count into `cnt_snap_o` on the next clock edge. Without a pulse, `cnt_snap_o` holds its value while the count moves.
- R10: In open-drain active-low mode, an asserted condition gives `cond_oe_o`=1 with `cond_o`=0, and a deasserted condition gives `cond_oe_o`=0. In open-drain mode `cond_o` is always 0.
- R11: In open-drain active-high mode (`cfg_pol_high_i`=1), an asserted condition gives `cond_oe_o`=0, and a deasserted condition gives `cond_oe_o`=1 with `cond_o`=0.
- R12: In tri-state mode (`cfg_tristate_i`=1), `cond_oe_o` is always 1. `cond_o` equals the active level when the condition is asserted and the inactive level otherwise.
- R13: With the error select set (`cfg_err_sel_i`=1), the condition shown on the pin is `par_err_i` rather than the interrupt. The configuration is written by a `cfg_we_i` pulse and takes effect on the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Test clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| evt_i | input | 1 | Asynchronous event input |
| run_i | input | 1 | Counting enabled |
| up_i | input | 1 | 1 = count up, 0 = count down |
| edge_fall_i | input | 1 | 1 = count falling edges, 0 = rising |
| load_i | input | 1 | Preset strobe |
| load_data_i | input | CNT_W | Preset value |
| capture_i | input | 1 | Snapshot strobe |
| cnt_snap_o | output | CNT_W | Captured count for readout |
| cfg_we_i | input | 1 | Output configuration write strobe |
| cfg_pol_high_i | input | 1 | 1 = active high, 0 = active low |
| cfg_tristate_i | input | 1 | 1 = tri-state drive, 0 = open drain |
| cfg_err_sel_i | input | 1 | 1 = pin shows parity error instead of interrupt |
| par_err_i | input | 1 | Instruction parity error flag |
| cond_o | output | 1 | Condition pin data level |
| cond_oe_o | output | 1 | Condition pin output enable |

## Verification
The hardest state to reach from the ports is the wrap interrupt. The only window onto the count is the snapshot, and a wrap needs 256 edges from a cleared count. The bench uses the load strobe to preset the count to 0xFE or 0x01 and then steps it one edge at a time. It reads the snapshot after each step, so it sees both the last value that does not wrap and the wrap itself. While the interrupt is held, the bench rewrites the configuration so that every polarity and drive combination is seen in both the asserted and the released state.

// File: rtl/evt_cnt_pkg.sv
package evt_cnt_pkg;
  typedef struct packed {
    logic pol_high;
    logic tristate;
    logic err_sel;
  } cond_cfg_t;

  localparam cond_cfg_t COND_CFG_RST = '{pol_high: 1'b0, tristate: 1'b0, err_sel: 1'b0};
endpackage

// File: rtl/evt_sync.sv
module evt_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic evt_i,
  input  logic fall_sel_i,
  output logic step_o
);
  logic [STAGES-1:0] sync_q;
  logic              prev_q;
  logic              lvl;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], evt_i};
      prev_q <= lvl;
    end
  end

  assign lvl    = sync_q[STAGES-1];
  assign step_o = fall_sel_i ? (prev_q & ~lvl) : (~prev_q & lvl);
endmodule

// File: rtl/evt_cnt_core.sv
module evt_cnt_core #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             step_i,
  input  logic             run_i,
  input  logic             up_i,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_data_i,
  input  logic             capture_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic [CNT_W-1:0] snap_o,
  output logic             irq_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  localparam logic [CNT_W-1:0] CNT_MIN = '0;

  logic [CNT_W-1:0] cnt_q, snap_q;
  logic             irq_q;
  logic             wrap;

  assign wrap = up_i ? (cnt_q == CNT_MAX) : (cnt_q == CNT_MIN);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      irq_q <= 1'b0;
    end else if (load_i) begin
      cnt_q <= load_data_i;
      irq_q <= 1'b0;
    end else if (run_i && step_i) begin
      cnt_q <= up_i ? cnt_q + 1'b1 : cnt_q - 1'b1;
      if (wrap) irq_q <= 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        snap_q <= '0;
    else if (capture_i) snap_q <= cnt_q;
  end

  assign cnt_o  = cnt_q;
  assign snap_o = snap_q;
  assign irq_o  = irq_q;
endmodule

// File: rtl/cond_drv.sv
module cond_drv
  import evt_cnt_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      cfg_we_i,
  input  cond_cfg_t cfg_i,
  input  logic      irq_i,
  input  logic      par_err_i,
  output cond_cfg_t cfg_o,
  output logic      cond_o,
  output logic      cond_oe_o
);
  cond_cfg_t cfg_q;
  logic      active, level;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       cfg_q <= COND_CFG_RST;
    else if (cfg_we_i) cfg_q <= cfg_i;
  end

  assign active = cfg_q.err_sel ? par_err_i : irq_i;
  assign level  = cfg_q.pol_high ? active : ~active;

  // open drain: only ever pull low
  assign cond_o    = cfg_q.tristate ? level : 1'b0;
  assign cond_oe_o = cfg_q.tristate ? 1'b1 : ~level;
  assign cfg_o     = cfg_q;
endmodule

// File: rtl/evt_cnt.sv
module evt_cnt
  import evt_cnt_pkg::*;
#(
  parameter int unsigned CNT_W       = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             evt_i,
  input  logic             run_i,
  input  logic             up_i,
  input  logic             edge_fall_i,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_data_i,
  input  logic             capture_i,
  output logic [CNT_W-1:0] cnt_snap_o,
  input  logic             cfg_we_i,
  input  logic             cfg_pol_high_i,
  input  logic             cfg_tristate_i,
  input  logic             cfg_err_sel_i,
  input  logic             par_err_i,
  output logic             cond_o,
  output logic             cond_oe_o
);
  logic             step;
  logic             irq;
  logic [CNT_W-1:0] cnt;
  cond_cfg_t        cfg_wr, cfg;

  evt_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i, .rst_ni, .evt_i, .fall_sel_i(edge_fall_i), .step_o(step)
  );

  evt_cnt_core #(.CNT_W(CNT_W)) u_core (
    .clk_i, .rst_ni, .step_i(step), .run_i, .up_i, .load_i, .load_data_i,
    .capture_i, .cnt_o(cnt), .snap_o(cnt_snap_o), .irq_o(irq)
  );

  assign cfg_wr = '{pol_high: cfg_pol_high_i, tristate: cfg_tristate_i, err_sel: cfg_err_sel_i};

  cond_drv u_drv (
    .clk_i, .rst_ni, .cfg_we_i, .cfg_i(cfg_wr), .irq_i(irq), .par_err_i,
    .cfg_o(cfg), .cond_o, .cond_oe_o
  );
endmodule

// File: rtl/evt_cnt_chk.sv
module evt_cnt_chk #(
  parameter int unsigned CNT_W = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             step,
  input logic             run_i,
  input logic             up_i,
  input logic             load_i,
  input logic [CNT_W-1:0] load_data_i,
  input logic             capture_i,
  input logic [CNT_W-1:0] cnt,
  input logic [CNT_W-1:0] cnt_snap_o,
  input logic             irq,
  input logic             cfg_tristate,
  input logic             cond_o,
  input logic             cond_oe_o
);
  p_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run_i && !load_i) |=> $stable(cnt));

  p_load_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> (cnt == $past(load_data_i)) && !irq);

  p_up_wrap_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && up_i && step && !load_i && cnt == '1) |=> (irq && cnt == '0));

  p_sticky_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq && !load_i) |=> irq);

  p_down_wrap_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && !up_i && step && !load_i && cnt == '0) |=> (irq && cnt == '1));

  p_snap_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    capture_i |=> cnt_snap_o == $past(cnt));

  p_snap_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !capture_i |=> $stable(cnt_snap_o));

  p_od_low_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cfg_tristate |-> !cond_o);

  p_tri_on_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_tristate |-> cond_oe_o);
endmodule

bind evt_cnt evt_cnt_chk #(.CNT_W(CNT_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .step(step), .run_i(run_i), .up_i(up_i),
  .load_i(load_i), .load_data_i(load_data_i), .capture_i(capture_i),
  .cnt(cnt), .cnt_snap_o(cnt_snap_o), .irq(irq), .cfg_tristate(cfg.tristate),
  .cond_o(cond_o), .cond_oe_o(cond_oe_o)
);

// File: tb/evt_cnt_tb.sv
`timescale 1ns/1ps
module evt_cnt_tb;
  localparam int W = 8;

  logic         clk = 1'b0, rst_n = 1'b0;
  logic         evt = 1'b0, run = 1'b0, up = 1'b1, efall = 1'b0;
  logic         load = 1'b0, cap = 1'b0;
  logic [W-1:0] ldata = '0;
  logic [W-1:0] snap;
  logic         cfg_we = 1'b0, pol_hi = 1'b0, tri_m = 1'b0, err_sel = 1'b0, perr = 1'b0;
  logic         cond, cond_oe;
  int           checks = 0, errors = 0;
  bit           done = 1'b0;

  always #2.5 clk = ~clk;

  evt_cnt u_dut (
    .clk_i(clk), .rst_ni(rst_n), .evt_i(evt), .run_i(run), .up_i(up),
    .edge_fall_i(efall), .load_i(load), .load_data_i(ldata), .capture_i(cap),
    .cnt_snap_o(snap), .cfg_we_i(cfg_we), .cfg_pol_high_i(pol_hi),
    .cfg_tristate_i(tri_m), .cfg_err_sel_i(err_sel), .par_err_i(perr),
    .cond_o(cond), .cond_oe_o(cond_oe)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic set_evt(input logic v);
    evt = v;
    cyc(4);
  endtask

  task automatic pulse(input int n);
    for (int i = 0; i < n; i++) begin
      set_evt(~evt);
      set_evt(~evt);
    end
  endtask

  task automatic read_cnt(output logic [W-1:0] v);
    cap = 1'b1; cyc(1); cap = 1'b0;
    v = snap;
  endtask

  task automatic do_load(input logic [W-1:0] v);
    ldata = v; load = 1'b1; cyc(1); load = 1'b0; cyc(1);
  endtask

  task automatic set_cfg(input logic ph, input logic tm, input logic es);
    pol_hi = ph; tri_m = tm; err_sel = es; cfg_we = 1'b1; cyc(1); cfg_we = 1'b0; cyc(1);
  endtask

  task automatic t_reset;
    logic [W-1:0] v;
    read_cnt(v);
    chk("R1 count", v, 8'h00);
    chk("R1 oe", cond_oe, 0);
  endtask

  task automatic t_up;
    logic [W-1:0] v;
    run = 1'b1; up = 1'b1; efall = 1'b0;
    pulse(5); read_cnt(v);
    chk("R2 five rising", v, 8'h05);
    evt = 1'b1; cyc(3); read_cnt(v);
    chk("R2 within three edges", v, 8'h06);
    evt = 1'b0; cyc(4);
  endtask

  task automatic t_fall;
    logic [W-1:0] v;
    efall = 1'b1; do_load(8'h10);
    set_evt(1'b1); read_cnt(v);
    chk("R3 rising ignored", v, 8'h10);
    set_evt(1'b0); read_cnt(v);
    chk("R3 falling counted", v, 8'h11);
    efall = 1'b0; cyc(1);
  endtask

  task automatic t_down;
    logic [W-1:0] v;
    up = 1'b0; do_load(8'h03);
    pulse(2); read_cnt(v);
    chk("R4 down", v, 8'h01);
  endtask

  task automatic t_hold;
    logic [W-1:0] v;
    run = 1'b0; pulse(3); read_cnt(v);
    chk("R5 hold", v, 8'h01);
    run = 1'b1;
  endtask

  task automatic t_wrap_up;
    logic [W-1:0] v;
    up = 1'b1; do_load(8'hFE);
    pulse(1); read_cnt(v);
    chk("R7 FF value", v, 8'hFF);
    chk("R7 no irq before wrap", cond_oe, 0);
    pulse(1); read_cnt(v);
    chk("R7 wrap value", v, 8'h00);
    chk("R10 asserted oe", cond_oe, 1);
    chk("R10 asserted level", cond, 0);
    pulse(1); read_cnt(v);
    chk("R7 sticky count", v, 8'h01);
    chk("R7 sticky irq", cond_oe, 1);
    do_load(8'h5A); read_cnt(v);
    chk("R6 load value", v, 8'h5A);
    chk("R6 irq cleared", cond_oe, 0);
  endtask

  task automatic t_wrap_down;
    logic [W-1:0] v;
    up = 1'b0; do_load(8'h01);
    pulse(1); read_cnt(v);
    chk("R8 zero value", v, 8'h00);
    chk("R8 no irq at zero", cond_oe, 0);
    pulse(1); read_cnt(v);
    chk("R8 wrap value", v, 8'hFF);
    chk("R8 irq", cond_oe, 1);
    up = 1'b1;
  endtask

  task automatic t_cfg;
    set_cfg(1'b1, 1'b0, 1'b0);
    chk("R11 asserted released", cond_oe, 0);
    set_cfg(1'b1, 1'b1, 1'b0);
    chk("R12 tri oe", cond_oe, 1);
    chk("R12 tri high", cond, 1);
    set_cfg(1'b0, 1'b1, 1'b0);
    chk("R12 tri active low", cond, 0);
    do_load(8'h00);
    chk("R12 tri deasserted", cond, 1);
    chk("R12 tri oe deasserted", cond_oe, 1);
    set_cfg(1'b1, 1'b0, 1'b0);
    chk("R11 deasserted oe", cond_oe, 1);
    chk("R11 deasserted level", cond, 0);
  endtask

  task automatic t_err;
    set_cfg(1'b0, 1'b0, 1'b1);
    perr = 1'b1; cyc(1);
    chk("R13 err oe", cond_oe, 1);
    chk("R13 err level", cond, 0);
    perr = 1'b0; cyc(1);
    chk("R13 err clear", cond_oe, 0);
    set_cfg(1'b0, 1'b0, 1'b0);
  endtask

  task automatic t_snap_hold;
    logic [W-1:0] v;
    do_load(8'h20); read_cnt(v);
    chk("R9 capture", v, 8'h20);
    pulse(2);
    chk("R9 hold without capture", snap, 8'h20);
    read_cnt(v);
    chk("R9 recapture", v, 8'h22);
  endtask

  initial begin
    cyc(3); rst_n = 1'b1; cyc(2);
    t_reset;
    t_up;
    t_fall;
    t_down;
    t_hold;
    t_wrap_up;
    t_wrap_down;
    t_cfg;
    t_err;
    t_snap_hold;
    done = 1'b1;
  end

  initial begin
    for (int i = 0; i < 20000 && !done; i++) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual hung expected done");
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule